// File: doc/BRIEF.md
# Stream Table Entry Locator

This block turns an incoming device stream identifier into the memory address of that device's entry in a linear stream table. The table is described by two programmed values: a 64-bit base register and a size exponent giving log2 of the number of entries. The block cleans up the base address and checks the identifier against both the size the hardware supports and the size software programmed. It then returns either the byte address of the 64-byte entry or a bad-identifier fault together with a ready-made event record.

Each request is a single-cycle strobe carrying the identifier and the configuration. The answer appears on the next clock edge as one registered response: a valid flag, a fault flag, the entry address and an eight-word event record. Two-level tables and the entry fetch itself belong to neighbouring logic.

Top module: `ste_locator`

## Requirements
- R1: A response (`rsp_valid` high for one cycle) appears exactly one clock after every cycle in which `req_valid` is high, and carries the result for that request.
- R2: The base address uses only bits 51 down to 6 of `base_reg`; bits 63..52 (including the attribute bit 62) and bits 5..0 never reach `rsp_addr`.
- R3: The effective size exponent E is the smaller of `cfg_log2size` and the parameter `SID_W` (16 by default). The masked base is aligned down to the table size by clearing its bits below E+6.
- R4: For an in-range identifier, `rsp_addr` equals the aligned base plus `req_sid` times 64, and `rsp_fault` is low.
- R5: An identifier is in range only when it is strictly less than 2^E; an identifier equal to 2^E faults.
- R6: Programming `cfg_log2size` above `SID_W` never widens the accepted range beyond 2^SID_W identifiers.
- R7: An out-of-range identifier raises `rsp_fault`, drives `rsp_addr` to zero, and sets event word 0 bits 7..0 to the code 0x02 and event word 1 to the full 32-bit identifier.
- R8: In a fault record, word 6 holds bits 31..0 and word 7 holds bits 63..32 of the attempted entry address (aligned base plus identifier times 64, modulo 2^64); words 2 to 5 and the upper 24 bits of word 0 are zero. Word w occupies `evt_rec` bits 32w+31..32w. With no fault the whole record is zero.
- R9: During and right after synchronous reset `rsp_valid`, `rsp_fault`, `rsp_addr` and `evt_rec` are all zero.
- R10: In a cycle after one with no request, `rsp_valid` and `rsp_fault` are low and `rsp_addr` and `evt_rec` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_sid | input | 32 | Incoming stream identifier |
| base_reg | input | 64 | Stream table base register |
| cfg_log2size | input | 6 | Programmed log2 of the entry count |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 1 | Bad-identifier fault |
| rsp_addr | output | 64 | Entry byte address, zero on fault |
| evt_rec | output | 256 | Eight-word event record, word 0 in the low bits |

## Verification
On every cycle the assertions check the response timing against the request strobe, that idle and fault responses carry zero in the fields they must, that a good address never has bits outside the legal window, and that a fault record carries the right code and empty middle words. The exact address sum, alignment to the programmed size, the equality boundary at 2^E, the clamp at `SID_W` and the word-6/7 address placement depend on arithmetic over the inputs, so only the bench's scenarios can show them. Those scenarios compare each response with a value computed independently from the requirements.

// File: rtl/ste_loc_pkg.sv
package ste_loc_pkg;

    localparam int SID_IN_W   = 32;
    localparam int ADDR_W     = 64;
    localparam int L2_W       = 6;
    localparam int WORD_W     = 32;
    localparam int EVT_WORDS  = 8;
    localparam int EVT_W      = WORD_W * EVT_WORDS;
    localparam int ENTRY_SHIFT = 6;

    localparam int ADDR_LO_BIT = 6;
    localparam int ADDR_HI_BIT = 51;

    localparam int WORD_CODE   = 0;
    localparam int WORD_SID    = 1;
    localparam int WORD_ADR_LO = 6;
    localparam int WORD_ADR_HI = 7;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [7:0] {
        EVT_NONE      = 8'h00,
        EVT_SID_RANGE = 8'h02
    } evt_code_e;

    typedef struct packed {
        logic              valid;
        logic              fault;
        addr_t             addr;
        logic [EVT_W-1:0]  evt;
    } loc_rsp_t;

    function automatic addr_t addr_field_mask();
        addr_t m;
        m = '0;
        for (int b = ADDR_LO_BIT; b <= ADDR_HI_BIT; b++) begin
            m[b] = 1'b1;
        end
        return m;
    endfunction

    function automatic addr_t low_clear_mask(input logic [L2_W:0] nbits);
        addr_t ones;
        ones = (addr_t'(1) << nbits) - addr_t'(1);
        return ~ones;
    endfunction

endpackage

// File: rtl/ste_sid_check.sv
module ste_sid_check
    import ste_loc_pkg::*;
#(
    parameter int SID_W = 16
) (
    input  logic [SID_IN_W-1:0] sid,
    input  logic [L2_W-1:0]     log2size,
    output logic [L2_W-1:0]     eff_log2,
    output logic                in_range
);
    localparam logic [L2_W-1:0] IMPL_LIMIT = L2_W'(SID_W);

    logic [SID_IN_W-1:0] upper_bits;

    always_comb begin
        if (log2size > IMPL_LIMIT) begin
            eff_log2 = IMPL_LIMIT;
        end else begin
            eff_log2 = log2size;
        end
    end

    // strict less-than: any bit at or above position eff_log2 means out of range
    always_comb begin
        upper_bits = sid >> eff_log2;
        in_range   = (upper_bits == '0);
    end

endmodule

// File: rtl/ste_base_align.sv
module ste_base_align
    import ste_loc_pkg::*;
(
    input  addr_t               base_reg,
    input  logic [L2_W-1:0]     eff_log2,
    input  logic [SID_IN_W-1:0] sid,
    output addr_t               entry_addr
);
    localparam addr_t FIELD_MASK = addr_field_mask();

    logic [L2_W:0] align_bits;
    addr_t         masked_base;
    addr_t         aligned_base;
    addr_t         sid_offset;

    always_comb begin
        align_bits   = {1'b0, eff_log2} + (L2_W+1)'(ENTRY_SHIFT);
        masked_base  = base_reg & FIELD_MASK;
        aligned_base = masked_base & low_clear_mask(align_bits);
        sid_offset   = addr_t'(sid) << ENTRY_SHIFT;
        entry_addr   = aligned_base + sid_offset;
    end

endmodule

// File: rtl/ste_evt_pack.sv
module ste_evt_pack
    import ste_loc_pkg::*;
(
    input  logic                fault,
    input  logic [SID_IN_W-1:0] sid,
    input  addr_t               fetch_addr,
    output logic [EVT_W-1:0]    record
);
    genvar w;
    generate
        for (w = 0; w < EVT_WORDS; w++) begin : g_word
            word_t val;
            always_comb begin
                val = '0;
                if (fault) begin
                    if (w == WORD_CODE) begin
                        val = word_t'(EVT_SID_RANGE);
                    end else if (w == WORD_SID) begin
                        val = word_t'(sid);
                    end else if (w == WORD_ADR_LO) begin
                        val = fetch_addr[WORD_W-1:0];
                    end else if (w == WORD_ADR_HI) begin
                        val = fetch_addr[ADDR_W-1:WORD_W];
                    end
                end
            end
            assign record[w*WORD_W +: WORD_W] = val;
        end
    endgenerate

endmodule

// File: rtl/ste_locator.sv
module ste_locator
    import ste_loc_pkg::*;
#(
    parameter int SID_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [31:0]          req_sid,
    input  logic [63:0]          base_reg,
    input  logic [5:0]           cfg_log2size,
    output logic                 rsp_valid,
    output logic                 rsp_fault,
    output logic [63:0]          rsp_addr,
    output logic [255:0]         evt_rec
);
    logic [L2_W-1:0]  eff_log2;
    logic             in_range;
    addr_t            entry_addr;
    logic [EVT_W-1:0] record_nxt;
    loc_rsp_t         rsp_nxt;
    loc_rsp_t         rsp_q;

    ste_sid_check #(.SID_W(SID_W)) u_check (
        .sid      (req_sid),
        .log2size (cfg_log2size),
        .eff_log2 (eff_log2),
        .in_range (in_range)
    );

    ste_base_align u_align (
        .base_reg   (base_reg),
        .eff_log2   (eff_log2),
        .sid        (req_sid),
        .entry_addr (entry_addr)
    );

    ste_evt_pack u_evt (
        .fault      (~in_range),
        .sid        (req_sid),
        .fetch_addr (entry_addr),
        .record     (record_nxt)
    );

    always_comb begin
        rsp_nxt = '0;
        if (req_valid) begin
            rsp_nxt.valid = 1'b1;
            rsp_nxt.fault = ~in_range;
            rsp_nxt.addr  = in_range ? entry_addr : '0;
            rsp_nxt.evt   = record_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_nxt;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_fault = rsp_q.fault;
    assign rsp_addr  = rsp_q.addr;
    assign evt_rec   = rsp_q.evt;

    // R1
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_fault && rsp_addr == '0 && evt_rec == '0));

    // R2
    addr_window_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> (rsp_addr[5:0] == '0 && rsp_addr[63:52] == '0));

    // R7
    fault_code_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_valid && rsp_addr == '0 && evt_rec[31:0] == 32'h0000_0002));

    // R8
    fault_middle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (evt_rec[191:64] == '0));

    // R8
    clean_record_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_fault |-> (evt_rec == '0));

endmodule

// File: tb/tb_ste_locator.sv
module tb_ste_locator;

    localparam int SID_W = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid;
    logic [31:0]  req_sid;
    logic [63:0]  base_reg;
    logic [5:0]   cfg_log2size;
    logic         rsp_valid;
    logic         rsp_fault;
    logic [63:0]  rsp_addr;
    logic [255:0] evt_rec;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic         exp_fault_q[$];
    logic [63:0]  exp_addr_q[$];
    logic [255:0] exp_evt_q[$];
    string        tag_q[$];

    always #2 clk = ~clk;

    ste_locator #(.SID_W(SID_W)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_sid(req_sid),
        .base_reg(base_reg), .cfg_log2size(cfg_log2size),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_addr(rsp_addr), .evt_rec(evt_rec)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Driver: applies one request and pushes the expected response
    task automatic send(input logic [31:0] sid, input logic [5:0] l2,
                        input logic [63:0] base, input string tag);
        int          e;
        logic [63:0] b;
        logic [63:0] a;
        logic [255:0] ev;
        bit          ok;
        @(negedge clk);
        req_valid    = 1'b1;
        req_sid      = sid;
        cfg_log2size = l2;
        base_reg     = base;
        e  = (int'(l2) < SID_W) ? int'(l2) : SID_W;
        b  = {12'h000, base[51:6], 6'b000000};
        b  = (b >> (e + 6)) << (e + 6);
        a  = b + {26'd0, sid, 6'd0};
        ok = ({32'd0, sid} < (64'd1 << e));
        ev = '0;
        if (!ok) begin
            ev[7:0]     = 8'h02;
            ev[63:32]   = sid;
            ev[223:192] = a[31:0];
            ev[255:224] = a[63:32];
        end
        exp_fault_q.push_back(!ok);
        exp_addr_q.push_back(ok ? a : 64'd0);
        exp_evt_q.push_back(ev);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_sid   = 32'hDEAD_BEEF;
        end
    endtask

    // Monitor: pops and compares on every response
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (rsp_valid) begin
                if (exp_fault_q.size() == 0) begin
                    check(1'b0, "R1", "unexpected response", 256'(rsp_valid), 256'(0));
                end else begin
                    logic         ef;
                    logic [63:0]  ea;
                    logic [255:0] ee;
                    string        t;
                    ef = exp_fault_q.pop_front();
                    ea = exp_addr_q.pop_front();
                    ee = exp_evt_q.pop_front();
                    t  = tag_q.pop_front();
                    check(rsp_fault == ef, t, "fault", 256'(rsp_fault), 256'(ef));
                    check(rsp_addr == ea, t, "addr", 256'(rsp_addr), 256'(ea));
                    check(evt_rec == ee, t, "event", evt_rec, ee);
                end
            end else begin
                // R10: an idle response carries nothing
                check(!rsp_fault && rsp_addr == '0 && evt_rec == '0, "R10", "idle outputs",
                      256'(rsp_addr) | evt_rec, 256'(0));
            end
        end
    end

    initial begin
        rst          = 1'b1;
        req_valid    = 1'b1;
        req_sid      = 32'h1;
        base_reg     = 64'hFFFF_FFFF_FFFF_FFFF;
        cfg_log2size = 6'd4;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(!rsp_valid && !rsp_fault && rsp_addr == '0 && evt_rec == '0, "R9", "reset outputs",
              256'(rsp_addr) | evt_rec | 256'(rsp_valid), 256'(0));
        req_valid = 1'b0;
        rst = 1'b0;
        idle(2);

        // R2 / R4: attribute and stray bits in the base must not reach the address
        send(32'd3, 6'd8, 64'h4000_0000_8000_403F, "R2");
        send(32'd0, 6'd8, 64'hFFF0_0012_3456_C000, "R2");
        // R3: misaligned base is aligned down to 2^(8+6) bytes
        send(32'd5, 6'd8, 64'h0000_0012_3456_7FC0, "R3");
        // R4: plain in-range lookups, back to back
        send(32'd255, 6'd8, 64'h0000_0000_1000_0000, "R4");
        send(32'd17,  6'd10, 64'h0000_00AB_CD00_0000, "R4");
        // R5: equality with 2^E is out of range
        send(32'd256, 6'd8, 64'h0000_0000_1000_0000, "R5");
        send(32'd0, 6'd0, 64'h0000_0000_2000_0040, "R5");
        send(32'd1, 6'd0, 64'h0000_0000_2000_0040, "R5");
        idle(1);
        // R6: size exponent above the implementation width is clamped
        send(32'h0000_FFFF, 6'd20, 64'h0000_0001_0000_0000, "R6");
        send(32'h0001_0000, 6'd20, 64'h0000_0001_0000_0000, "R6");
        send(32'h0001_0000, 6'd63, 64'h0000_0001_2345_0000, "R6");
        // R7 / R8: fault records with a large identifier and a high base
        send(32'hFFFF_FFFF, 6'd12, 64'h000F_FFFF_FFFF_FFC0, "R7");
        send(32'h8000_0001, 6'd16, 64'h4008_7654_3210_0000, "R8");
        idle(2);
        // R1: mixed stream with gaps
        send(32'd7, 6'd4, 64'h0000_0000_0000_1000, "R1");
        idle(1);
        send(32'd16, 6'd4, 64'h0000_0000_0000_1000, "R1");
        send(32'd15, 6'd4, 64'h0000_0000_0000_1000, "R1");
        idle(3);
        check(exp_fault_q.size() == 0, "R1", "responses outstanding",
              256'(exp_fault_q.size()), 256'(0));
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule